// File: doc/BRIEF.md
# Operand2 Barrel Shifter Unit

This combinational unit forms the second source operand of a 32-bit data-processing operation. It takes a packed 12-bit operand field and an immediate-select flag, along with the already-fetched values of the operand register and the count register. It returns the shifted 32-bit operand and a shifter carry that the flag logic consumes. It does not read the register file itself. Instead, it decodes the operand field and presents the two register index fields on its outputs, so that the surrounding pipeline can fetch the values it needs.

The operand field is decoded in one of three ways. When the immediate-select flag is set, the low field becomes a zero-extended constant. When the flag is clear and field bit 4 is 0, a 5-bit count held in the field itself shifts the operand register. When the flag is clear and field bit 4 is 1, the low byte of the count register supplies the count. One of four shift kinds is then applied: logical left, logical right, arithmetic right or rotate right.

Top module: `operand2_shifter`

## Requirements
- R1: With immSel = 1, shiftOut is opField zero-extended to 32 bits, no shift is applied, and carryOut equals carryIn.
- R2: With immSel = 0 and opField[4] = 0, the count is opField[11:7] and the shift kind is opField[6:5], coded 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. rmIdx always shows opField[3:0].
- R3: With immSel = 0 and opField[4] = 1, the count is rsValue[7:0] and rsValue[31:8] has no effect. rsIdx always shows opField[11:8].
- R4: A count of zero gives shiftOut = rmValue and carryOut = carryIn, for every shift kind.
- R5: A logical left shift by n from 1 to 32 fills the low bits with zero, and carryOut is the last bit shifted out, which is rmValue[32-n]. For n above 32, both shiftOut and carryOut are 0.
- R6: A logical right shift by n from 1 to 32 fills the high bits with zero, and carryOut is rmValue[n-1]. For n above 32, both shiftOut and carryOut are 0.
- R7: An arithmetic right shift fills the vacated high bits with rmValue[31], and carryOut is the last bit shifted out. A count of 32 or more gives 32 copies of rmValue[31], and carryOut equals rmValue[31].
- R8: A rotate right by a nonzero n rotates by n mod 32, moving bit 0 into bit 31 on each step, and carryOut equals shiftOut[31]. For example, 0x0000FFFF rotated by 16 gives 0xFFFF0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opField | input | 12 | Packed operand field |
| immSel | input | 1 | 1 selects the zero-extended immediate path |
| rmValue | input | 32 | Value of the operand register |
| rsValue | input | 32 | Value of the count register (only the low byte is used) |
| carryIn | input | 1 | Current carry flag |
| rmIdx | output | 4 | Operand register index field |
| rsIdx | output | 4 | Count register index field |
| shiftOut | output | 32 | Prepared second operand |
| carryOut | output | 1 | Shifter carry for the flag logic |

## Verification
The assertions assume that rmValue and rsValue already belong to the indices that the unit presents, and that all inputs are stable when the outputs are sampled. The bench keeps within these assumptions: it drives a complete input set, waits half a clock, and only then samples. It sweeps every shift kind with every field count from 0 to 31 and with register counts across 0 to 40, plus large counts, against several operand patterns. For register-mode counts, it sets the upper bits of rsValue to junk, so that a decoder that uses more than the low byte produces a mismatch.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int AMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shKind_e;

  typedef struct packed {
    logic             passImm;
    shKind_e          kind;
    logic [AMT_W-1:0] amount;
  } shCtrl_t;
endpackage

// File: rtl/opsh_ctrl.sv
module opsh_ctrl
  import opsh_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic [FIELD_W-1:0] opField,
  input  logic               immSel,
  input  logic [DATA_W-1:0]  rsValue,
  output shCtrl_t            ctrl,
  output logic [IDX_W-1:0]   rmIdx,
  output logic [IDX_W-1:0]   rsIdx
);
  localparam int CNT_W   = 5;
  localparam int CNT_LSB = FIELD_W - CNT_W;
  localparam int RS_LSB  = FIELD_W - IDX_W;
  localparam int REG_BIT = 4;

  logic regCount;

  always_comb begin
    regCount     = opField[REG_BIT];
    rmIdx        = opField[IDX_W-1:0];
    rsIdx        = opField[FIELD_W-1:RS_LSB];
    ctrl.passImm = immSel;
    ctrl.kind    = shKind_e'(opField[6:5]);
    if (regCount)
      ctrl.amount = rsValue[AMT_W-1:0];
    else
      ctrl.amount = AMT_W'(opField[FIELD_W-1:CNT_LSB]);
  end

  // R3
  always_comb begin
    if (!immSel && opField[REG_BIT])
      rs_low_byte_chk: assert (ctrl.amount == rsValue[AMT_W-1:0]);
  end

  // R2
  always_comb begin
    if (!immSel && !opField[REG_BIT])
      field_count_range_chk: assert (ctrl.amount < AMT_W'(32));
  end
endmodule

// File: rtl/opsh_datapath.sv
module opsh_datapath
  import opsh_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int DATA_W  = 32
) (
  input  shCtrl_t            ctrl,
  input  logic [FIELD_W-1:0] opField,
  input  logic [DATA_W-1:0]  rmValue,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  shiftOut,
  output logic               carryOut
);
  localparam int ROT_W  = $clog2(DATA_W);
  localparam int WIDE_W = 2*DATA_W + 1;

  logic [WIDE_W-1:0] lslWide;
  logic [DATA_W:0]   lsrWide;
  logic [DATA_W:0]   asrWide;
  logic [DATA_W-1:0] rotStage [0:ROT_W];
  logic              amtZero;

  assign amtZero = (ctrl.amount == '0);

  assign lslWide = {{(DATA_W+1){1'b0}}, rmValue} << ctrl.amount;
  assign lsrWide = {rmValue, 1'b0} >> ctrl.amount;
  assign asrWide = $signed({rmValue, 1'b0}) >>> ctrl.amount;

  assign rotStage[0] = rmValue;
  for (genvar s = 0; s < ROT_W; s++) begin : g_rot
    localparam int STEP = 1 << s;
    assign rotStage[s+1] = ctrl.amount[s]
      ? {rotStage[s][STEP-1:0], rotStage[s][DATA_W-1:STEP]}
      : rotStage[s];
  end

  always_comb begin
    shiftOut = rmValue;
    carryOut = carryIn;
    if (ctrl.passImm) begin
      shiftOut = {{(DATA_W-FIELD_W){1'b0}}, opField};
      carryOut = carryIn;
    end else if (!amtZero) begin
      unique case (ctrl.kind)
        SH_LSL: begin
          shiftOut = lslWide[DATA_W-1:0];
          carryOut = lslWide[DATA_W];
        end
        SH_LSR: begin
          shiftOut = lsrWide[DATA_W:1];
          carryOut = lsrWide[0];
        end
        SH_ASR: begin
          shiftOut = asrWide[DATA_W:1];
          carryOut = asrWide[0];
        end
        SH_ROR: begin
          shiftOut = rotStage[ROT_W];
          carryOut = rotStage[ROT_W][DATA_W-1];
        end
        default: begin
          shiftOut = rmValue;
          carryOut = carryIn;
        end
      endcase
    end
  end

  // R1
  always_comb begin
    if (ctrl.passImm)
      imm_upper_zero_chk: assert (shiftOut[DATA_W-1:FIELD_W] == '0 && carryOut == carryIn);
  end

  // R4
  always_comb begin
    if (!ctrl.passImm && amtZero)
      zero_count_pass_chk: assert (shiftOut == rmValue && carryOut == carryIn);
  end

  // R5
  always_comb begin
    if (!ctrl.passImm && ctrl.kind == SH_LSL && ctrl.amount > 8'(DATA_W))
      lsl_flush_chk: assert (shiftOut == '0 && !carryOut);
  end

  // R6
  always_comb begin
    if (!ctrl.passImm && ctrl.kind == SH_LSR && !amtZero)
      lsr_top_clear_chk: assert (!shiftOut[DATA_W-1]);
  end

  // R7
  always_comb begin
    if (!ctrl.passImm && ctrl.kind == SH_ASR)
      asr_sign_keep_chk: assert (shiftOut[DATA_W-1] == rmValue[DATA_W-1]);
  end

  // R8
  always_comb begin
    if (!ctrl.passImm && ctrl.kind == SH_ROR)
      ror_popcount_chk: assert ($countones(shiftOut) == $countones(rmValue));
  end
endmodule

// File: rtl/operand2_shifter.sv
module operand2_shifter
  import opsh_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic [FIELD_W-1:0] opField,
  input  logic               immSel,
  input  logic [DATA_W-1:0]  rmValue,
  input  logic [DATA_W-1:0]  rsValue,
  input  logic               carryIn,
  output logic [IDX_W-1:0]   rmIdx,
  output logic [IDX_W-1:0]   rsIdx,
  output logic [DATA_W-1:0]  shiftOut,
  output logic               carryOut
);
  shCtrl_t ctrl;

  opsh_ctrl #(.FIELD_W(FIELD_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .opField(opField),
    .immSel (immSel),
    .rsValue(rsValue),
    .ctrl   (ctrl),
    .rmIdx  (rmIdx),
    .rsIdx  (rsIdx)
  );

  opsh_datapath #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .opField (opField),
    .rmValue (rmValue),
    .carryIn (carryIn),
    .shiftOut(shiftOut),
    .carryOut(carryOut)
  );
endmodule

// File: tb/operand2_shifter_test.sv
module operand2_shifter_test;
  logic        clk = 1'b0;
  logic [11:0] opField = '0;
  logic        immSel = 1'b0;
  logic [31:0] rmValue = '0;
  logic [31:0] rsValue = '0;
  logic        carryIn = 1'b0;
  logic [3:0]  rmIdx, rsIdx;
  logic [31:0] shiftOut;
  logic        carryOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  operand2_shifter uut (
    .opField(opField), .immSel(immSel), .rmValue(rmValue), .rsValue(rsValue),
    .carryIn(carryIn), .rmIdx(rmIdx), .rsIdx(rsIdx),
    .shiftOut(shiftOut), .carryOut(carryOut)
  );

  // step-by-step reference: returns {carry, value}
  function automatic logic [32:0] refShift(input logic [1:0] kind, input int n,
                                           input logic [31:0] v, input logic c);
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string kindTag(input logic [1:0] kind, input int n);
    if (n == 0) return "R4";
    case (kind)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [11:0] f, input logic imm, input logic [31:0] rm,
                       input logic [31:0] rs, input logic c);
    @(posedge clk);
    opField = f; immSel = imm; rmValue = rm; rsValue = rs; carryIn = c;
    @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got carry=%0b value=%08h, expected carry=%0b value=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000FFFF; pats[1] = 32'h80000001; pats[2] = 32'hDEADBEEF;
    pats[3] = 32'h12345678; pats[4] = 32'hFFFFFFFF; pats[5] = 32'h7FFFFFFE;

    // initial state with idle inputs (R1)
    apply(12'h000, 1'b1, 32'h0, 32'h0, 1'b0);
    checkVal("R1 idle", {carryOut, shiftOut}, 33'h0);

    // R1: immediate path sweep
    for (int f = 0; f < 4096; f += 37) begin
      apply(12'(f), 1'b1, 32'hCAFEF00D, 32'hFFFFFFFF, f[0]);
      checkVal("R1", {carryOut, shiftOut}, {f[0], 20'h0, 12'(f)});
    end

    // R2: field-count mode, every kind and count
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++) begin
            logic [11:0] f;
            f = {5'(n), 2'(k), 1'b0, 4'(p + 3)};
            apply(f, 1'b0, pats[p], 32'hFFFFFF00 | 32'(p), c[0]);
            checkVal({"R2/", kindTag(2'(k), n)}, {carryOut, shiftOut},
                     refShift(2'(k), n, pats[p], c[0]));
            checks++;
            if (rmIdx !== 4'(p + 3) || rsIdx !== 4'(n >> 1)) begin
              errors++;
              $display("FAIL R2 idx: got rm=%0d rs=%0d, expected rm=%0d rs=%0d",
                       rmIdx, rsIdx, p + 3, n >> 1);
            end
          end

    // R3: register-count mode, upper bits of count register are junk
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 44; n++) begin
          int amt;
          logic [11:0] f;
          amt = (n < 41) ? n : ((n == 41) ? 64 : ((n == 42) ? 96 : 255));
          f = {4'(k + 9), 1'b0, 2'(k), 1'b1, 4'(p)};
          apply(f, 1'b0, pats[p], {24'hA5C3E1, 8'(amt)}, n[0]);
          checkVal({"R3/", kindTag(2'(k), amt)}, {carryOut, shiftOut},
                   refShift(2'(k), amt, pats[p], n[0]));
          checks++;
          if (rsIdx !== 4'(k + 9)) begin
            errors++;
            $display("FAIL R3 idx: got rs=%0d, expected rs=%0d", rsIdx, k + 9);
          end
        end

    // R8: worked rotate example
    apply({5'd16, 2'b11, 1'b0, 4'h2}, 1'b0, 32'h0000FFFF, 32'h0, 1'b0);
    checkVal("R8 example", {carryOut, shiftOut}, {1'b1, 32'hFFFF0000});

    // R7: register count 32 on negative value
    apply({4'h1, 1'b0, 2'b10, 1'b1, 4'h0}, 1'b0, 32'h80000000, 32'h00000120, 1'b0);
    checkVal("R7 full", {carryOut, shiftOut}, {1'b1, 32'hFFFFFFFF});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule